// File: doc/BRIEF.md
# Comparator Control and Interrupt Register

This block is a byte-wide control and status register placed between a simple CPU register bus and the digital output of an analog comparator. Software uses it to turn on the comparator's hysteresis and to choose the polarity of the comparator output. Both settings are driven straight to the analog side. The raw comparator output enters the clock domain through a two-flop synchroniser. The block then presents a copy of that signal, inverted when software asks for it.

The same polarity bit also chooses which transition of the synchronised comparator signal counts as an event. With the bit clear, a low-to-high transition is an event. With it set, a high-to-low transition is an event. An event latches a flag. Reading the register clears the flag, and a write never changes it. The interrupt request is a registered level that is high while the flag and the enable bit are both set.

Register layout (byte): bit 7 hysteresis enable, bit 6 reserved (reads 0), bit 5 polarity/edge select, bit 4 event flag (read-only), bit 3 interrupt enable, bits 2..0 unused (read 0).

Top module: `cmp_ctl_reg`

## Requirements
- R1: After reset the register reads 0x80, `hyst_en` is 1, `irq` is 0, and `cmp_out` is 0.
- R2: Bit 7 is written from `bus_wdata[7]` on a write strobe, reads back, and drives `hyst_en` from the clock edge that performs the write.
- R3: Bit 6 and bits 2..0 always read 0, and writes to them have no effect on any output.
- R4: `cmp_out` equals the raw input delayed through two flops, XORed with bit 5. A change on `cmp_raw` reaches `cmp_out` after the second rising clock edge.
- R5: With bit 5 = 0, a 0-to-1 transition of the synchronised input sets the flag (bit 4). The flag becomes visible after the third rising edge following the raw change.
- R6: With bit 5 = 1, a 1-to-0 transition of the synchronised input sets the flag, and a 0-to-1 transition does not.
- R7: A read strobe clears the flag at the clock edge that ends the read. During the read cycle, `bus_rdata` shows the flag value from before the clear.
- R8: A write strobe leaves the flag unchanged, whatever value `bus_wdata[4]` holds.
- R9: If a qualifying transition and a read occur in the same cycle, the flag is set after that edge.
- R10: Changing bit 5 while the input is steady does not set the flag.
- R11: Bit 3 resets to 0 and is read/write. `irq` is a registered output equal to flag AND bit 3, updated at the same edge as the flag and the enable.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (current register contents) |
| cmp_raw | input | 1 | Asynchronous comparator output |
| cmp_out | output | 1 | Synchronised, optionally inverted comparator output |
| hyst_en | output | 1 | Hysteresis enable to the analog comparator |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check several rules on every cycle:
- a detected transition always sets the flag;
- a read with no transition clears it;
- a write alone keeps it;
- the flag never rises without a detected transition;
- the interrupt equals flag AND enable;
- a write loads the hysteresis bit.

Only the bench's scenarios can show the end-to-end latency from `cmp_raw` through the synchroniser, the edge polarity chosen by bit 5, and the read-versus-event race at every offset. They also cover toggling the polarity while the input is steady, and the read value of the reserved bits. All of these are compared against a history-queue model on every clock.

// File: rtl/cmpctl_pkg.sv
package cmpctl_pkg;
    localparam int REG_W     = 8;
    localparam int HYST_POS  = 7;
    localparam int POL_POS   = 5;
    localparam int EVT_POS   = 4;
    localparam int IEN_POS   = 3;
    localparam int SYNC_LEN  = 2;

    typedef struct packed {
        logic hyst;
        logic pol;
        logic ien;
    } ctl_bits_t;

    localparam ctl_bits_t CTL_RESET = '{hyst: 1'b1, pol: 1'b0, ien: 1'b0};
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int TOP = STAGES - 1;

    generate
        if (STAGES < 2) begin : g_single
            logic stg_d, stg_q;
            always_comb stg_d = async_in;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= 1'b0;
                else        stg_q <= stg_d;
            end
            assign sync_out = stg_q;
        end else begin : g_chain
            logic [TOP:0] chain_d, chain_q;
            always_comb chain_d = {chain_q[TOP-1:0], async_in};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end
            assign sync_out = chain_q[TOP];
        end
    endgenerate
endmodule

// File: rtl/cmp_ctl_bits.sv
module cmp_ctl_bits
    import cmpctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_bits_t        ctl_q,
    output ctl_bits_t        ctl_nxt
);
    ctl_bits_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.hyst = wr_data[HYST_POS];
            ctl_d.pol  = wr_data[POL_POS];
            ctl_d.ien  = wr_data[IEN_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign ctl_nxt = ctl_d;

    AST_WR_LOADS_HYST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q.hyst == $past(wr_data[HYST_POS]))); // R2
    AST_IDLE_HOLDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/cmp_evt_flag.sv
module cmp_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol,
    input  logic rd_en,
    input  logic wr_en,
    output logic evt_q,
    output logic evt_nxt,
    output logic edge_hit
);
    typedef struct packed {
        logic last;
        logic evt;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        rise     = sync_in & ~st_q.last;
        fall     = ~sync_in & st_q.last;
        edge_hit = pol ? fall : rise;
        st_d      = st_q;
        st_d.last = sync_in;
        if (edge_hit)   st_d.evt = 1'b1;
        else if (rd_en) st_d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_q   = st_q.evt;
    assign evt_nxt = st_d.evt;

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> evt_q); // R5
    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !edge_hit) |=> !evt_q); // R7
    AST_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !edge_hit) |=> $stable(evt_q)); // R8
    AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> $past(edge_hit)); // R10
endmodule

// File: rtl/cmp_ctl_reg.sv
module cmp_ctl_reg
    import cmpctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             cmp_raw,
    output logic             cmp_out,
    output logic             hyst_en,
    output logic             irq
);
    ctl_bits_t ctl_q, ctl_nxt;
    logic      cmp_sync_s;
    logic      evt_q, evt_nxt, edge_hit;
    logic      irq_d, irq_q;

    cmp_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_raw),
        .sync_out (cmp_sync_s)
    );

    cmp_ctl_bits u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_data (bus_wdata),
        .ctl_q   (ctl_q),
        .ctl_nxt (ctl_nxt)
    );

    cmp_evt_flag u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (cmp_sync_s),
        .pol      (ctl_q.pol),
        .rd_en    (bus_rd),
        .wr_en    (bus_wr),
        .evt_q    (evt_q),
        .evt_nxt  (evt_nxt),
        .edge_hit (edge_hit)
    );

    always_comb begin
        irq_d = evt_nxt & ctl_nxt.ien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    always_comb begin
        bus_rdata           = '0;
        bus_rdata[HYST_POS] = ctl_q.hyst;
        bus_rdata[POL_POS]  = ctl_q.pol;
        bus_rdata[EVT_POS]  = evt_q;
        bus_rdata[IEN_POS]  = ctl_q.ien;
    end

    assign cmp_out = cmp_sync_s ^ ctl_q.pol;
    assign hyst_en = ctl_q.hyst;
    assign irq     = irq_q;

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (evt_q & ctl_q.ien)); // R11
    AST_RACE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && edge_hit) |=> evt_q); // R9
endmodule

// File: tb/cmp_ctl_reg_test.sv
`timescale 1ns/1ps
module cmp_ctl_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_raw = 1'b0;
    logic       cmp_out, hyst_en, irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    bit m_hyst, m_pol, m_ien, m_flag, m_irq;
    bit hist[$];   // hist[0] = raw sampled at most recent edge

    always #2.5 clk = ~clk;

    cmp_ctl_reg uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
        .cmp_out(cmp_out), .hyst_en(hyst_en), .irq(irq)
    );

    function automatic [7:0] exp_rdata();
        return {m_hyst, 1'b0, m_pol, m_flag, m_ien, 3'b000};
    endfunction

    task automatic model_reset();
        m_hyst = 1; m_pol = 0; m_ien = 0; m_flag = 0; m_irq = 0;
        hist = {0, 0, 0, 0};
    endtask

    task automatic model_edge(input bit w, input bit r, input bit [7:0] d, input bit raw);
        bit sync_now, sync_old, hit;
        sync_now = hist[1];
        sync_old = hist[2];
        hit = m_pol ? (!sync_now && sync_old) : (sync_now && !sync_old);
        if (hit)    m_flag = 1;
        else if (r) m_flag = 0;
        if (w) begin
            m_hyst = d[7]; m_pol = d[5]; m_ien = d[3];
        end
        m_irq = m_flag & m_ien;
        hist.push_front(raw);
        void'(hist.pop_back());
    endtask

    task automatic compare(input string tag);
        bit [7:0] er;
        bit eo;
        er = exp_rdata();
        eo = hist[1] ^ m_pol;
        n_vec++;
        if (bus_rdata !== er || cmp_out !== eo || hyst_en !== m_hyst || irq !== m_irq) begin
            n_bad++;
            $display("FAIL %s: rdata=%h out=%b hyst=%b irq=%b expected rdata=%h out=%b hyst=%b irq=%b",
                     tag, bus_rdata, cmp_out, hyst_en, irq, er, eo, m_hyst, m_irq);
        end
    endtask

    task automatic step(input string tag, input bit w, input bit r, input bit [7:0] d, input bit raw);
        bus_wr = w; bus_rd = r; bus_wdata = d; cmp_raw = raw;
        @(posedge clk);
        model_edge(w, r, d, raw);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        compare(tag);
    endtask

    task automatic idle(input string tag, input int n, input bit raw);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 8'h00, raw);
    endtask

    initial begin
        bit [15:0] lfsr;
        bit cur;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1 reset value");
        idle("R1", 2, 0);

        // R2: hysteresis bit write/readback and pin
        step("R2 clear hyst", 1, 0, 8'h00, 0);
        step("R2 set hyst",   1, 0, 8'h80, 0);

        // R3: reserved and unused bits
        step("R3 write all ones", 1, 0, 8'hFF, 0);
        step("R3 write reserved only", 1, 0, 8'h47, 0);
        idle("R3", 2, 0);

        // R4 and R5: rising-edge event with polarity clear, enable on
        step("R11 enable", 1, 0, 8'h88, 0);
        idle("R5 pre", 2, 0);
        step("R4 raw rise", 0, 0, 8'h00, 1);
        idle("R5 latency", 4, 1);
        step("R8 write flag bit 0", 1, 0, 8'h88, 1);
        step("R8 write flag bit 1", 1, 0, 8'h98, 1);
        step("R7 read clears", 0, 1, 8'h00, 1);
        idle("R7 after", 2, 1);

        // R10: polarity toggles while input steady
        step("R10 pol on",  1, 0, 8'hA8, 1);
        idle("R10", 3, 1);
        step("R10 pol off", 1, 0, 8'h88, 1);
        idle("R10", 3, 1);

        // R6: falling edge with polarity set; rise must not flag
        step("R6 pol on", 1, 0, 8'hA8, 1);
        idle("R6 fall", 5, 0);
        step("R7 read", 0, 1, 8'h00, 0);
        idle("R6 rise ignored", 5, 1);

        // R11: enable cleared drops irq while flag held
        idle("R6 fall again", 5, 0);
        step("R11 disable", 1, 0, 8'hA0, 0);
        step("R11 enable",  1, 0, 8'hA8, 0);
        step("R7 read", 0, 1, 8'h00, 0);

        // R9: read at every offset relative to an input change
        step("R9 pol off", 1, 0, 8'h88, 0);
        idle("R9", 3, 0);
        for (int off = 0; off < 5; off++) begin
            cur = (off % 2 == 0);
            step("R9 change", 0, 0, 8'h00, cur);
            for (int k = 0; k < 5; k++)
                step("R9 race", 0, (k == off), 8'h00, cur);
            step("R9 flush", 0, 1, 8'h00, cur);
            idle("R9", 2, cur);
        end

        // mixed traffic
        lfsr = 16'hACE1;
        cur = 0;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'b101) cur = ~cur;
            step("mix R5 R6 R7 R8 R11", lfsr[7:4] == 4'h3, lfsr[11:9] == 3'b010, lfsr[15:8], cur);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule